// File: doc/BRIEF.md
# Multi-Group ADC Conversion Sequencer

This block shares one analog-to-digital converter among three conversion groups: an event group (ID 0), group 1 (ID 1) and group 2 (ID 2). Each group holds a channel mask, a repeat-or-single-pass mode bit and a freeze-enable bit. Writing a group's configuration with a non-zero mask requests conversion. Writing it with a zero mask cancels the group. The sequencer hands the converter one channel at a time. It waits for the converter's done strobe, tags the result with its channel and group, and then decides at that channel boundary which group receives the next slot.

A group whose freeze-enable bit is set yields the converter to any other group that has a fresh request. It stops only at the end of the channel already converting. Its position is kept, and it resumes at the next unconverted channel once no fresh work remains. When several groups have been parked, they resume in last-parked, first-resumed order, so nested preemptions unwind correctly.

Top module: `adc_group_seq`

## Requirements
- R1: A conversion that has started is never cut short. After each `conv_start` pulse, no further `conv_start` occurs until the result of that conversion has been reported on `res_valid`.
- R2: Within a group, selected channels are converted in ascending channel-number order. Each `conv_done` produces a one-cycle `res_valid` on the following cycle, carrying the channel (`res_ch`) and the group ID (`res_grp`: 0 = event, 1 = group 1, 2 = group 2).
- R3: With the mode bit clear (single pass), a group converts each selected channel exactly once and then goes idle. Its `seq_end` bit (bit index = group ID) pulses for one cycle together with the result of the last channel.
- R4: With the mode bit set (repeat), a group returns to its lowest selected channel after its highest one and continues indefinitely. `seq_end` pulses for one cycle together with the result of the highest channel on every wrap.
- R5: A configuration write with a non-zero mask requests conversion. On an idle sequencer, `conv_start` is low on the cycle after the write edge and high, with the lowest selected channel, on the cycle after that.
- R6: A configuration write with a zero mask cancels the group, whether it is converting, waiting or parked. At most the conversion already in flight completes, and no further channel of that group is converted.
- R7: A group with freeze-enable clear that holds the converter keeps it until its sequence completes, even if other groups request conversion in the meantime.
- R8: Among fresh requests, groups with freeze-enable clear win over groups with freeze-enable set. Within each class, the event group beats group 1, and group 1 beats group 2.
- R9: A freeze-enabled group that holds the converter is parked at the next channel boundary when any other group has a fresh request.
- R10: A parked group resumes at its next unconverted channel, not its first. It resumes only when no fresh request is waiting, and the most recently parked group resumes first.
- R11: A configuration write addressed to group ID 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_grp | input | 2 | Group addressed by the write (0 event, 1, 2) |
| cfg_mask | input | NCH | Channel mask; non-zero requests, zero cancels |
| cfg_cont | input | 1 | 1 = repeat mode, 0 = single pass |
| cfg_frz | input | 1 | 1 = freeze-enable (group yields to others) |
| conv_start | output | 1 | One-cycle request to the converter |
| conv_ch | output | CH_W | Channel of the conversion in flight |
| conv_grp | output | 2 | Group of the conversion in flight |
| conv_done | input | 1 | One-cycle completion strobe from the converter |
| res_valid | output | 1 | Result tag valid, one cycle |
| res_ch | output | CH_W | Channel the result belongs to |
| res_grp | output | 2 | Group the result belongs to |
| seq_end | output | 3 | Per-group end-of-sequence / wrap pulse |

## Verification
The bench reproduces a two-level preemption: a repeating, freeze-enabled group 1 is parked by group 2, and group 2 is in turn parked by the event group. The bench checks that group 2 resumes at its remaining channel before group 1 resumes at its fourth channel. A design that restarted a parked group from its lowest channel, or that resumed parked groups oldest first, would produce a visibly different result order. Other tests cancel a parked group while another group runs, and check that a non-freeze group keeps the converter against a higher-ranked newcomer. A further test confirms that a freeze-enabled fresh request loses to a non-freeze one, where a plain fixed-priority arbiter would get the order wrong. Repeat-mode wrap pulses, the two-cycle start latency and writes to the unused group ID are checked at the ports.

// File: rtl/adc_seq_pkg.sv
// Package: shared types and constants for the conversion sequencer.
// Assumes exactly three groups; group ID doubles as base priority (0 highest).
package adc_seq_pkg;
    localparam int NGRP = 3;
    localparam int GW   = 2;

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_PEND = 2'd1,
        GS_RUN  = 2'd2,
        GS_SUSP = 2'd3
    } grp_state_e;
endpackage

// File: rtl/adc_seq_group.sv
// Module: per-group state holder.
// Stores mask, mode, freeze bit and sequence position, and reports the next
// channel to convert. Assumes start, suspend and adv are never asserted in
// the same cycle; a configuration write overrides all three.
module adc_seq_group
    import adc_seq_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [NCH-1:0]  wr_mask,
    input  logic            wr_cont,
    input  logic            wr_frz,
    input  logic            start,
    input  logic            suspend,
    input  logic            adv,
    input  logic [CH_W-1:0] adv_ch,
    output grp_state_e      state,
    output logic            frz,
    output logic [CH_W-1:0] cur_ch,
    output logic            eos
);
    logic [NCH-1:0] mask;
    logic           cont;
    logic [CH_W:0]  pos;
    logic [NCH-1:0] rem;
    logic [NCH-1:0] rem_after;

    // Purpose: find channels at or above the position and above the channel just done.
    always_comb begin
        rem       = '0;
        rem_after = '0;
        cur_ch    = '0;
        for (int i = 0; i < NCH; i++) begin
            rem[i]       = mask[i] && (i >= int'(pos));
            rem_after[i] = mask[i] && (i > int'(adv_ch));
        end
        for (int i = NCH - 1; i >= 0; i--) begin
            if (rem[i]) cur_ch = CH_W'(i);
        end
    end

    // Purpose: configuration load, state transitions and position advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask  <= '0;
            cont  <= 1'b0;
            frz   <= 1'b0;
            pos   <= '0;
            state <= GS_IDLE;
            eos   <= 1'b0;
        end else begin
            eos <= 1'b0;
            if (wr) begin
                mask  <= wr_mask;
                cont  <= wr_cont;
                frz   <= wr_frz;
                pos   <= '0;
                state <= (|wr_mask) ? GS_PEND : GS_IDLE;
            end else begin
                if (start) begin
                    state <= GS_RUN;
                end else if (suspend) begin
                    state <= GS_SUSP;
                end
                if (adv && state == GS_RUN) begin
                    if (|rem_after) begin
                        pos <= {1'b0, adv_ch} + (CH_W+1)'(1);
                    end else begin
                        eos <= 1'b1;
                        pos <= '0;
                        if (!cont) state <= GS_IDLE;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/adc_seq_arb.sv
// Module: slot arbiter.
// Picks the group for the next conversion slot from the group states. Assumes
// at most one group is running. Keeps a recency matrix of parked groups so the
// latest parked group resumes first.
module adc_seq_arb
    import adc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NGRP-1:0] is_run,
    input  logic [NGRP-1:0] is_pend,
    input  logic [NGRP-1:0] is_susp,
    input  logic [NGRP-1:0] frz,
    input  logic [NGRP-1:0] susp_evt,
    output logic            win_vld,
    output logic [GW-1:0]   win_grp
);
    logic [NGRP-1:0] newer [NGRP];
    logic [GW-1:0]   run_g;
    logic [GW-1:0]   nf_g;
    logic [GW-1:0]   f_g;
    logic [GW-1:0]   susp_g;
    logic [NGRP-1:0] fresh_nf;
    logic [NGRP-1:0] fresh_f;
    logic            cand;

    // Purpose: locate the running group, the best fresh groups and the latest parked group.
    always_comb begin
        fresh_nf = is_pend & ~frz;
        fresh_f  = is_pend & frz;
        run_g    = '0;
        nf_g     = '0;
        f_g      = '0;
        susp_g   = '0;
        cand     = 1'b0;
        for (int i = NGRP - 1; i >= 0; i--) begin
            if (is_run[i])   run_g = GW'(i);
            if (fresh_nf[i]) nf_g  = GW'(i);
            if (fresh_f[i])  f_g   = GW'(i);
        end
        for (int i = 0; i < NGRP; i++) begin
            cand = is_susp[i];
            for (int j = 0; j < NGRP; j++) begin
                if (is_susp[j] && newer[j][i]) cand = 1'b0;
            end
            if (cand) susp_g = GW'(i);
        end
    end

    // Purpose: apply the slot priority order.
    always_comb begin
        win_vld = 1'b1;
        win_grp = '0;
        if ((|is_run) && !frz[run_g]) begin
            win_grp = run_g;
        end else if (|fresh_nf) begin
            win_grp = nf_g;
        end else if (|fresh_f) begin
            win_grp = f_g;
        end else if (|is_run) begin
            win_grp = run_g;
        end else if (|is_susp) begin
            win_grp = susp_g;
        end else begin
            win_vld = 1'b0;
        end
    end

    // Purpose: mark a newly parked group as newer than every other group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NGRP; i++) newer[i] <= '0;
        end else begin
            for (int i = 0; i < NGRP; i++) begin
                if (susp_evt[i]) begin
                    for (int j = 0; j < NGRP; j++) begin
                        if (j != i) begin
                            newer[i][j] <= 1'b1;
                            newer[j][i] <= 1'b0;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: converter handshake controller.
// Issues one conversion per slot, holds the channel/group of the conversion in
// flight, and reports tagged results. Assumes conv_done arrives only while busy;
// a stray strobe when idle is ignored.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 win_vld,
    input  logic [GW-1:0]        win_grp,
    input  logic [NGRP*CH_W-1:0] grp_ch,
    input  logic [NGRP-1:0]      is_run,
    input  logic                 conv_done,
    output logic                 conv_start,
    output logic [CH_W-1:0]      conv_ch,
    output logic [GW-1:0]        conv_grp,
    output logic [NGRP-1:0]      start_g,
    output logic [NGRP-1:0]      susp_g,
    output logic [NGRP-1:0]      adv_g,
    output logic [CH_W-1:0]      adv_ch,
    output logic                 res_valid,
    output logic [CH_W-1:0]      res_ch,
    output logic [GW-1:0]        res_grp
);
    logic            busy;
    logic            go;
    logic [NGRP-1:0] win_oh;
    logic [NGRP-1:0] cur_oh;

    // Purpose: derive slot grant, park and advance strobes for the groups.
    always_comb begin
        go     = !busy && win_vld;
        win_oh = '0;
        cur_oh = '0;
        for (int i = 0; i < NGRP; i++) begin
            win_oh[i] = (win_grp == GW'(i));
            cur_oh[i] = (conv_grp == GW'(i));
        end
        start_g = go ? win_oh : '0;
        susp_g  = go ? (is_run & ~win_oh) : '0;
        adv_g   = (busy && conv_done) ? cur_oh : '0;
        adv_ch  = conv_ch;
    end

    // Purpose: track the conversion in flight and emit start and result strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            conv_start <= 1'b0;
            conv_ch    <= '0;
            conv_grp   <= '0;
            res_valid  <= 1'b0;
            res_ch     <= '0;
            res_grp    <= '0;
        end else begin
            conv_start <= go;
            res_valid  <= 1'b0;
            if (go) begin
                busy     <= 1'b1;
                conv_grp <= win_grp;
                conv_ch  <= grp_ch[win_grp*CH_W +: CH_W];
            end else if (busy && conv_done) begin
                busy      <= 1'b0;
                res_valid <= 1'b1;
                res_ch    <= conv_ch;
                res_grp   <= conv_grp;
            end
        end
    end
endmodule

// File: rtl/adc_group_seq.sv
// Module: top of the multi-group conversion sequencer.
// Decodes configuration writes, instantiates one state holder per group, the
// slot arbiter and the converter controller. Assumes a single shared converter
// that answers every start with exactly one done strobe.
module adc_group_seq
    import adc_seq_pkg::*;
#(
    parameter int NCH  = 16,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_grp,
    input  logic [NCH-1:0]  cfg_mask,
    input  logic            cfg_cont,
    input  logic            cfg_frz,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_ch,
    output logic [1:0]      conv_grp,
    input  logic            conv_done,
    output logic            res_valid,
    output logic [CH_W-1:0] res_ch,
    output logic [1:0]      res_grp,
    output logic [2:0]      seq_end
);
    logic [NGRP-1:0]      wr_g;
    logic [NGRP-1:0]      is_run;
    logic [NGRP-1:0]      is_pend;
    logic [NGRP-1:0]      is_susp;
    logic [NGRP-1:0]      frz_g;
    logic [NGRP-1:0]      start_g;
    logic [NGRP-1:0]      susp_g;
    logic [NGRP-1:0]      adv_g;
    logic [NGRP*CH_W-1:0] grp_ch;
    logic [CH_W-1:0]      adv_ch;
    logic                 win_vld;
    logic [GW-1:0]        win_grp;
    grp_state_e           gstate [NGRP];

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            // Purpose: decode the write for this group and classify its state.
            always_comb begin
                wr_g[g]    = cfg_we && (cfg_grp == GW'(g));
                is_run[g]  = (gstate[g] == GS_RUN);
                is_pend[g] = (gstate[g] == GS_PEND);
                is_susp[g] = (gstate[g] == GS_SUSP);
            end

            adc_seq_group #(.NCH(NCH), .CH_W(CH_W)) u_grp (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr      (wr_g[g]),
                .wr_mask (cfg_mask),
                .wr_cont (cfg_cont),
                .wr_frz  (cfg_frz),
                .start   (start_g[g]),
                .suspend (susp_g[g]),
                .adv     (adv_g[g]),
                .adv_ch  (adv_ch),
                .state   (gstate[g]),
                .frz     (frz_g[g]),
                .cur_ch  (grp_ch[g*CH_W +: CH_W]),
                .eos     (seq_end[g])
            );
        end
    endgenerate

    adc_seq_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_run   (is_run),
        .is_pend  (is_pend),
        .is_susp  (is_susp),
        .frz      (frz_g),
        .susp_evt (susp_g),
        .win_vld  (win_vld),
        .win_grp  (win_grp)
    );

    adc_seq_ctrl #(.CH_W(CH_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_vld    (win_vld),
        .win_grp    (win_grp),
        .grp_ch     (grp_ch),
        .is_run     (is_run),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .conv_ch    (conv_ch),
        .conv_grp   (conv_grp),
        .start_g    (start_g),
        .susp_g     (susp_g),
        .adv_g      (adv_g),
        .adv_ch     (adv_ch),
        .res_valid  (res_valid),
        .res_ch     (res_ch),
        .res_grp    (res_grp)
    );
endmodule

// File: rtl/adc_group_seq_chk.sv
// Module: property checker bound into the sequencer top.
// Tracks the conversion in flight from the port strobes and checks handshake,
// tagging and ownership rules.
module adc_group_seq_chk #(
    parameter int CH_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            conv_start,
    input logic [CH_W-1:0] conv_ch,
    input logic [1:0]      conv_grp,
    input logic            res_valid,
    input logic [CH_W-1:0] res_ch,
    input logic [1:0]      res_grp,
    input logic [2:0]      seq_end,
    input logic [2:0]      is_run
);
    logic            inflight;
    logic [CH_W-1:0] st_ch;
    logic [1:0]      st_grp;

    // Purpose: remember the conversion issued on the ports until its result shows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight <= 1'b0;
            st_ch    <= '0;
            st_grp   <= '0;
        end else if (conv_start) begin
            inflight <= 1'b1;
            st_ch    <= conv_ch;
            st_grp   <= conv_grp;
        end else if (res_valid) begin
            inflight <= 1'b0;
        end
    end

    p_no_abort_r1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !inflight);

    p_result_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (inflight && res_ch == st_ch && res_grp == st_grp));

    p_seq_end_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(seq_end));

    p_seq_end_with_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|seq_end) |-> res_valid);

    p_single_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(is_run) <= 1);

    p_valid_group_r11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (conv_grp != 2'd3));
endmodule

bind adc_group_seq adc_group_seq_chk #(.CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .conv_ch    (conv_ch),
    .conv_grp   (conv_grp),
    .res_valid  (res_valid),
    .res_ch     (res_ch),
    .res_grp    (res_grp),
    .seq_end    (seq_end),
    .is_run     (is_run)
);

// File: tb/adc_group_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each; converter modelled as fixed latency.
module adc_group_seq_tb_top;
    localparam int NCH  = 16;
    localparam int CH_W = 4;
    localparam int LAT  = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cfg_we;
    logic [1:0]      cfg_grp;
    logic [NCH-1:0]  cfg_mask;
    logic            cfg_cont;
    logic            cfg_frz;
    logic            conv_start;
    logic [CH_W-1:0] conv_ch;
    logic [1:0]      conv_grp;
    logic            conv_done;
    logic            res_valid;
    logic [CH_W-1:0] res_ch;
    logic [1:0]      res_grp;
    logic [2:0]      seq_end;

    int nchk  = 0;
    int nfail = 0;
    int got_q[$];
    int exp_q[$];
    int eos_cnt [3];
    int starts  = 0;
    int cnv_cnt = 0;

    always #2.5 clk = ~clk;

    adc_group_seq #(.NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_grp(cfg_grp),
        .cfg_mask(cfg_mask), .cfg_cont(cfg_cont), .cfg_frz(cfg_frz),
        .conv_start(conv_start), .conv_ch(conv_ch), .conv_grp(conv_grp),
        .conv_done(conv_done), .res_valid(res_valid), .res_ch(res_ch),
        .res_grp(res_grp), .seq_end(seq_end)
    );

    // Converter model and result monitor, both on the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            cnv_cnt   = 0;
            conv_done = 1'b0;
        end else begin
            conv_done = 1'b0;
            if (cnv_cnt > 0) begin
                cnv_cnt = cnv_cnt - 1;
                if (cnv_cnt == 0) conv_done = 1'b1;
            end
            if (conv_start) begin
                cnv_cnt = LAT;
                starts  = starts + 1;
            end
            if (res_valid) got_q.push_back(int'(res_grp) * 100 + int'(res_ch));
            for (int g = 0; g < 3; g++) if (seq_end[g]) eos_cnt[g]++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        got_q.delete();
        for (int g = 0; g < 3; g++) eos_cnt[g] = 0;
        starts = 0;
    endtask

    task automatic wr(input int g, input int mask, input bit cont, input bit frz);
        cfg_we   = 1'b1;
        cfg_grp  = 2'(g);
        cfg_mask = NCH'(mask);
        cfg_cont = cont;
        cfg_frz  = frz;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic wait_res(input int n);
        for (int k = 0; k < 3000 && got_q.size() < n; k++) @(negedge clk);
    endtask

    task automatic wait_start(input string req, input int g, input int ch);
        int k = 0;
        while (!(conv_start && conv_grp == 2'(g) && conv_ch == CH_W'(ch)) && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk(k < 3000, req, "start seen for group*100+ch", k, g * 100 + ch);
    endtask

    task automatic cmp_seq(input string req);
        chk(got_q.size() >= exp_q.size(), req, "result count", got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(got_q[i] == exp_q[i], req, $sformatf("result %0d (grp*100+ch)", i),
                got_q[i], exp_q[i]);
    endtask

    task automatic t_reset();
        chk(conv_start == 1'b0, "R1", "conv_start after reset", conv_start, 0);
        chk(res_valid == 1'b0, "R2", "res_valid after reset", res_valid, 0);
        chk(seq_end == 3'b0, "R3", "seq_end after reset", seq_end, 0);
    endtask

    task automatic t_single_pass();
        clear_log();
        wr(1, 16'h00A4, 1'b0, 1'b0);
        chk(conv_start == 1'b0, "R5", "conv_start one cycle after write", conv_start, 0);
        @(negedge clk);
        chk(conv_start == 1'b1, "R5", "conv_start two cycles after write", conv_start, 1);
        chk(conv_ch == 4'd2, "R5", "first channel", conv_ch, 2);
        wait_res(3);
        exp_q = '{102, 105, 107};
        cmp_seq("R2");
        repeat (30) @(negedge clk);
        chk(got_q.size() == 3, "R3", "no conversions after single pass", got_q.size(), 3);
        chk(eos_cnt[1] == 1, "R3", "seq_end pulses group 1", eos_cnt[1], 1);
    endtask

    task automatic t_repeat_and_cancel();
        int n0;
        clear_log();
        wr(2, 16'h000A, 1'b1, 1'b0);
        wait_res(5);
        exp_q = '{201, 203, 201, 203, 201};
        cmp_seq("R4");
        chk(eos_cnt[2] == 2, "R4", "wrap pulses after five results", eos_cnt[2], 2);
        n0 = got_q.size();
        wr(2, 0, 1'b1, 1'b0);
        repeat (10) @(negedge clk);
        n0 = got_q.size() - n0;
        chk(n0 <= 1, "R6", "results after cancel of running group", n0, 1);
        n0 = got_q.size();
        repeat (40) @(negedge clk);
        chk(got_q.size() == n0, "R6", "quiet after cancel", got_q.size(), n0);
    endtask

    task automatic t_keep_converter();
        clear_log();
        wr(2, 16'h0007, 1'b0, 1'b0);
        wait_start("R7", 2, 0);
        wr(0, 16'h0200, 1'b0, 1'b0);
        wait_res(4);
        exp_q = '{200, 201, 202, 9};
        cmp_seq("R7");
        chk(starts == 4, "R1", "one start per result", starts, 4);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_priority();
        clear_log();
        wr(1, 16'h0018, 1'b0, 1'b0);
        wait_start("R8", 1, 3);
        wr(2, 16'h0040, 1'b0, 1'b0);
        wr(0, 16'h0080, 1'b0, 1'b0);
        wait_res(4);
        exp_q = '{103, 104, 7, 206};
        cmp_seq("R8");
        repeat (20) @(negedge clk);
        clear_log();
        wr(1, 16'h0008, 1'b0, 1'b0);
        wait_start("R8", 1, 3);
        wr(0, 16'h0080, 1'b0, 1'b1);
        wr(2, 16'h0040, 1'b0, 1'b0);
        wait_res(3);
        exp_q = '{103, 206, 7};
        cmp_seq("R8");
        repeat (20) @(negedge clk);
    endtask

    task automatic t_nested_park();
        clear_log();
        wr(1, 16'h001E, 1'b1, 1'b1);
        wait_start("R9", 1, 3);
        wr(2, 16'h0520, 1'b0, 1'b1);
        wait_start("R9", 2, 8);
        wr(0, 16'hC200, 1'b0, 1'b0);
        wait_res(11);
        exp_q = '{101, 102, 103, 205, 208, 9, 14, 15, 210, 104, 101};
        cmp_seq("R10");
        chk(eos_cnt[2] == 1, "R3", "group 2 end pulse", eos_cnt[2], 1);
        chk(eos_cnt[0] == 1, "R3", "event end pulse", eos_cnt[0], 1);
        wr(1, 0, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_cancel_parked();
        clear_log();
        wr(1, 16'h0003, 1'b1, 1'b1);
        wait_start("R9", 1, 1);
        wr(2, 16'h0030, 1'b0, 1'b0);
        wait_start("R9", 2, 4);
        wr(1, 0, 1'b1, 1'b1);
        wait_res(4);
        exp_q = '{100, 101, 204, 205};
        cmp_seq("R9");
        repeat (40) @(negedge clk);
        chk(got_q.size() == 4, "R6", "parked group stays cancelled", got_q.size(), 4);
    endtask

    task automatic t_bad_group();
        clear_log();
        wr(3, 16'h00FF, 1'b0, 1'b0);
        repeat (30) @(negedge clk);
        chk(starts == 0, "R11", "starts after write to ID 3", starts, 0);
        chk(got_q.size() == 0, "R11", "results after write to ID 3", got_q.size(), 0);
    endtask

    initial begin
        rst_n    = 1'b0;
        cfg_we   = 1'b0;
        cfg_grp  = '0;
        cfg_mask = '0;
        cfg_cont = 1'b0;
        cfg_frz  = 1'b0;
        for (int g = 0; g < 3; g++) eos_cnt[g] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_pass();
        t_repeat_and_cancel();
        t_keep_converter();
        t_priority();
        t_nested_park();
        t_cancel_parked();
        t_bad_group();
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule